// File: doc/BRIEF.md
# Serial-Link FPGA Configuration Loader

This block loads the configuration memory of a second, downstream FPGA over a serial peripheral link where that target is the listener. A start pulse and a byte count begin a load. The block then pulls the target's active-low reset and the link's chip select low together and holds them. After it releases reset, it checks that the target's configuration-done input reads low and waits out the target's housekeeping time with the chip select still low.

Next it takes the bitstream from a valid/ready byte stream and shifts each byte out in SPI mode 0, most significant bit first. After the last byte it confirms that configuration-done has gone high. It then sends zero-filled bytes so the target receives the extra clocks that start the loaded design.

Every timing figure is given in microseconds or hertz and is turned into clock-cycle counts from the core clock frequency at elaboration time. A request marked as partial reconfiguration is refused: the block raises the error flag and the link pins do not move. A successful load ends with a one-cycle done pulse. A failure leaves the error flag set until the next start.

Top module: `spi_cfg_loader`

## Requirements
- R1: After system reset, cfg_rst_n_o=1, cfg_cs_n_o=1, cfg_sck_o=0, and busy_o, done_o, err_o and byte_ready_o are all 0.
- R2: A start pulse with partial_i=0, given while idle, drives cfg_rst_n_o and cfg_cs_n_o low together. cfg_rst_n_o stays low for exactly ceil(CLK_HZ*RST_US/1e6) cycles, which is 100 cycles with the defaults. The chip select is low for every cycle in which reset is low.
- R3: cfg_done_i is sampled in the first cycle after cfg_rst_n_o returns high. If it reads 1, the load stops: err_o is set, cfg_cs_n_o returns high, and no serial clock edge is produced.
- R4: After reset is released, cfg_cs_n_o stays low and no serial clock edge occurs for at least ceil(CLK_HZ*HK_US/1e6) cycles, which is the housekeeping wait.
- R5: The serial link runs in mode 0. cfg_sck_o rests low, and each half period lasts ceil(CLK_HZ/(2*SCK_HZ)) cycles, so adjacent rising edges within a byte are 8 cycles apart at 100 MHz and 12.5 MHz.
- R6: Exactly len_i bytes are accepted through the handshake. They are sent in order with the most significant bit first. cfg_mosi_o changes only while cfg_sck_o is low.
- R7: byte_ready_o stays 0 during the housekeeping wait and for as long as a byte is being shifted out.
- R8: In the cycle after the last data byte finishes shifting, cfg_done_i must read 1. If it reads 0, err_o is set, cfg_cs_n_o returns high, no padding is sent and done_o does not pulse.
- R9: Once done has been confirmed, PAD_BYTES bytes of value 0x00 are shifted out (7 by default, which gives 56 clocks and meets the minimum of 49). done_o then pulses.
- R10: A start pulse with partial_i=1 sets err_o. cfg_rst_n_o, cfg_cs_n_o and cfg_sck_o keep their idle values.
- R11: done_o is high for exactly one cycle per successful load. err_o stays set until the next start pulse, which clears it. A start pulse while busy_o=1 has no effect.
- R12: cfg_sck_o is 0 in every cycle in which cfg_cs_n_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| start_i | input | 1 | One-cycle request to begin a load |
| partial_i | input | 1 | Request is for partial reconfiguration (refused) |
| len_i | input | LEN_W | Bitstream length in bytes, latched at start |
| byte_data_i | input | 8 | Bitstream byte |
| byte_valid_i | input | 1 | Bitstream byte is valid |
| byte_ready_o | output | 1 | Loader accepts a byte this cycle |
| cfg_done_i | input | 1 | Target configuration-done input |
| cfg_rst_n_o | output | 1 | Target active-low reset |
| cfg_cs_n_o | output | 1 | Serial link chip select, active low |
| cfg_sck_o | output | 1 | Serial clock |
| cfg_mosi_o | output | 1 | Serial data to target |
| busy_o | output | 1 | A load is in progress |
| done_o | output | 1 | One-cycle pulse on a successful load |
| err_o | output | 1 | Sticky error flag |

## Verification
Reset is released exactly RST cycles after the start edge. The done sample falls one cycle after that. The first serial rising edge comes no sooner than the housekeeping count plus one cycle after reset release. Each bit costs two half periods, and done_o rises in the cycle after the last padding byte ends. The bench records every pin at the falling clock edge, so it measures each interval as a count of whole cycles and compares the count with figures it works out on its own from the timing parameters. Serial bytes are rebuilt from cfg_mosi_o at each rising edge of cfg_sck_o and compared in order with a queue that the driver fills. This makes the check independent of the exact cycle on which a byte arrives, and only the order and the gaps matter.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RESET,
    ST_PRECHK,
    ST_HOUSE,
    ST_DATA,
    ST_POSTCHK,
    ST_PAD,
    ST_FINISH
  } seq_state_e;

  // cycles covering a span of microseconds, rounded up
  function automatic int unsigned us_cycles(input int unsigned clk_hz,
                                            input int unsigned usec);
    longint unsigned prod;
    prod = longint'(clk_hz) * longint'(usec);
    return int'((prod + 64'd999_999) / 64'd1_000_000);
  endfunction

  // core cycles per serial-clock half period, rounded up so the rate never exceeds the target
  function automatic int unsigned half_cycles(input int unsigned clk_hz,
                                              input int unsigned sck_hz);
    longint unsigned two_f;
    longint unsigned h;
    two_f = 64'd2 * longint'(sck_hz);
    h = (longint'(clk_hz) + two_f - 64'd1) / two_f;
    return (h == 64'd0) ? 1 : int'(h);
  endfunction

endpackage

// File: rtl/spi_cfg_timer.sv
module spi_cfg_timer #(
  parameter int unsigned TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] value_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= value_i - TW'(1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - TW'(1);
    end
  end

  assign zero_o = (cnt_q == '0);

  // R4: once expired the timer stays expired until reloaded
  timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_o && !load_i |=> zero_o);
endmodule

// File: rtl/spi_cfg_shifter.sv
module spi_cfg_shifter #(
  parameter int unsigned HALF = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic [7:0] data_i,
  output logic       busy_o,
  output logic       sck_o,
  output logic       mosi_o
);
  localparam int unsigned HW = (HALF < 2) ? 1 : $clog2(HALF);

  logic [7:0]    sreg_q;
  logic [2:0]    bit_q;
  logic [HW-1:0] ph_q;
  logic          sck_q;
  logic          busy_q;
  logic          half_end;

  assign half_end = (ph_q == HW'(HALF - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg_q <= '0;
      bit_q  <= '0;
      ph_q   <= '0;
      sck_q  <= 1'b0;
      busy_q <= 1'b0;
    end else if (!busy_q) begin
      if (load_i) begin
        sreg_q <= data_i;
        bit_q  <= '0;
        ph_q   <= '0;
        sck_q  <= 1'b0;
        busy_q <= 1'b1;
      end
    end else if (half_end) begin
      ph_q  <= '0;
      sck_q <= ~sck_q;
      if (sck_q) begin
        if (bit_q == 3'd7) begin
          busy_q <= 1'b0;
        end else begin
          sreg_q <= {sreg_q[6:0], 1'b0};
          bit_q  <= bit_q + 3'd1;
        end
      end
    end else begin
      ph_q <= ph_q + HW'(1);
    end
  end

  assign busy_o = busy_q;
  assign sck_o  = sck_q;
  assign mosi_o = busy_q & sreg_q[7];

  // R6: data line moves only while the serial clock is low
  mosi_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi_o) |-> !sck_o);

  // R5: the serial clock rests low when no byte is in flight
  sck_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !sck_o);
endmodule

// File: rtl/spi_cfg_loader.sv
module spi_cfg_loader
  import spi_cfg_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 100_000_000,
  parameter int unsigned SCK_HZ    = 12_500_000,
  parameter int unsigned RST_US    = 1,
  parameter int unsigned HK_US     = 1200,
  parameter int unsigned PAD_BYTES = 7,
  parameter int unsigned LEN_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             partial_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [7:0]       byte_data_i,
  input  logic             byte_valid_i,
  output logic             byte_ready_o,
  input  logic             cfg_done_i,
  output logic             cfg_rst_n_o,
  output logic             cfg_cs_n_o,
  output logic             cfg_sck_o,
  output logic             cfg_mosi_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);
  localparam int unsigned TW      = 32;
  localparam int unsigned RST_CYC = us_cycles(CLK_HZ, RST_US);
  localparam int unsigned HK_CYC  = us_cycles(CLK_HZ, HK_US);
  localparam int unsigned HALF    = half_cycles(CLK_HZ, SCK_HZ);
  localparam int unsigned PW      = $clog2(PAD_BYTES + 1);

  seq_state_e       state_q, state_d;
  logic [LEN_W-1:0] remain_q;
  logic [PW-1:0]    pad_q;
  logic             err_q;

  logic             tmr_load;
  logic [TW-1:0]    tmr_val;
  logic             tmr_zero;
  logic             shift_busy;
  logic             shift_load;
  logic [7:0]       shift_data;
  logic             shift_mosi;

  // named events for the checks
  logic             go_full;
  logic             go_partial;
  logic             accept;
  logic             pad_load;
  logic             precheck_fail;
  logic             postcheck_fail;

  assign go_full        = (state_q == ST_IDLE) && start_i && !partial_i;
  assign go_partial     = (state_q == ST_IDLE) && start_i && partial_i;
  assign byte_ready_o   = (state_q == ST_DATA) && !shift_busy && (remain_q != '0);
  assign accept         = byte_ready_o && byte_valid_i;
  assign pad_load       = (state_q == ST_PAD) && !shift_busy && (pad_q != '0);
  assign precheck_fail  = (state_q == ST_PRECHK) && cfg_done_i;
  assign postcheck_fail = (state_q == ST_POSTCHK) && !cfg_done_i;

  assign shift_load = accept || pad_load;
  assign shift_data = accept ? byte_data_i : 8'h00;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = TW'(RST_CYC);
    unique case (state_q)
      ST_IDLE: begin
        if (go_full) begin
          state_d  = ST_RESET;
          tmr_load = 1'b1;
        end
      end
      ST_RESET:   if (tmr_zero) state_d = ST_PRECHK;
      ST_PRECHK: begin
        if (cfg_done_i) begin
          state_d = ST_IDLE;
        end else begin
          state_d  = ST_HOUSE;
          tmr_load = 1'b1;
          tmr_val  = TW'(HK_CYC);
        end
      end
      ST_HOUSE:   if (tmr_zero) state_d = ST_DATA;
      ST_DATA:    if (remain_q == '0 && !shift_busy) state_d = ST_POSTCHK;
      ST_POSTCHK: state_d = cfg_done_i ? ST_PAD : ST_IDLE;
      ST_PAD:     if (!shift_busy && pad_q == '0) state_d = ST_FINISH;
      ST_FINISH:  state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      remain_q <= '0;
      pad_q    <= '0;
      err_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (go_full) remain_q <= len_i;
      else if (accept) remain_q <= remain_q - LEN_W'(1);
      if (state_q == ST_POSTCHK) pad_q <= PW'(PAD_BYTES);
      else if (pad_load) pad_q <= pad_q - PW'(1);
      if (go_full) err_q <= 1'b0;
      else if (go_partial || precheck_fail || postcheck_fail) err_q <= 1'b1;
    end
  end

  spi_cfg_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (tmr_load),
    .value_i (tmr_val),
    .zero_o  (tmr_zero)
  );

  spi_cfg_shifter #(.HALF(HALF)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (shift_load),
    .data_i (shift_data),
    .busy_o (shift_busy),
    .sck_o  (cfg_sck_o),
    .mosi_o (shift_mosi)
  );

  assign cfg_mosi_o  = shift_mosi;
  assign cfg_rst_n_o = (state_q != ST_RESET);
  assign cfg_cs_n_o  = (state_q == ST_IDLE);
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_FINISH);
  assign err_o       = err_q;

  // R2
  rst_with_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rst_n_o |-> !cfg_cs_n_o);

  // R3
  precheck_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    precheck_fail |=> cfg_cs_n_o && err_o && !cfg_sck_o);

  // R7
  ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready_o |-> !cfg_sck_o && !cfg_cs_n_o && cfg_rst_n_o);

  // R8
  postcheck_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    postcheck_fail |=> cfg_cs_n_o && err_o && !done_o);

  // R10
  partial_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_partial |=> cfg_cs_n_o && cfg_rst_n_o && err_o);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R12
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_cs_n_o |-> !cfg_sck_o);
endmodule

// File: tb/spi_cfg_loader_tb_top.sv
module spi_cfg_loader_tb_top;
  localparam int unsigned CLK_HZ = 100_000_000;
  localparam int unsigned SCK_HZ = 12_500_000;
  localparam int unsigned RST_US = 1;
  localparam int unsigned HK_US  = 3;
  localparam int unsigned PADN   = 7;

  // bench-side restatement: 100 cycles per microsecond, 4-cycle half period
  localparam int CYC_PER_US = CLK_HZ / 1_000_000;
  localparam int EXP_RST    = CYC_PER_US * RST_US;
  localparam int EXP_HK     = CYC_PER_US * HK_US;
  localparam int EXP_BITGAP = CLK_HZ / SCK_HZ;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        partial_i = 1'b0;
  logic [15:0] len_i = '0;
  logic [7:0]  byte_data_i = '0;
  logic        byte_valid_i = 1'b0;
  logic        byte_ready_o;
  logic        tgt_done = 1'b0;
  logic        cfg_rst_n_o, cfg_cs_n_o, cfg_sck_o, cfg_mosi_o;
  logic        busy_o, done_o, err_o;

  always #5 clk = ~clk;

  spi_cfg_loader #(
    .CLK_HZ(CLK_HZ), .SCK_HZ(SCK_HZ), .RST_US(RST_US), .HK_US(HK_US),
    .PAD_BYTES(PADN), .LEN_W(16)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .partial_i(partial_i),
    .len_i(len_i), .byte_data_i(byte_data_i), .byte_valid_i(byte_valid_i),
    .byte_ready_o(byte_ready_o), .cfg_done_i(tgt_done),
    .cfg_rst_n_o(cfg_rst_n_o), .cfg_cs_n_o(cfg_cs_n_o), .cfg_sck_o(cfg_sck_o),
    .cfg_mosi_o(cfg_mosi_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  int tests = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // scoreboard
  logic [7:0] exp_q[$];
  logic [7:0] tx_q[$];

  // monitor state
  int   cyc = 0;
  logic p_rst = 1'b1, p_cs = 1'b1, p_sck = 1'b0;
  int   rst_run = 0, rst_width = 0, rst_rise_cyc = 0;
  bit   first_sck = 1'b0;
  int   hk_gap = 0, last_rise = 0, min_gap = 1000;
  int   cs_falls = 0, rst_falls = 0, sck_rises = 0;
  int   idle_viol = 0, ready_viol = 0, done_cycles = 0;
  int   mis = 0, extra = 0, nbits = 0;
  logic [7:0] shreg = '0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!cfg_rst_n_o) rst_run++;
      if (p_rst && !cfg_rst_n_o) rst_falls++;
      if (!p_rst && cfg_rst_n_o) begin
        rst_width = rst_run; rst_run = 0; rst_rise_cyc = cyc; first_sck = 1'b0;
      end
      if (p_cs && !cfg_cs_n_o) cs_falls++;
      if (cfg_cs_n_o && cfg_sck_o) idle_viol++;
      if (byte_ready_o && (cfg_sck_o || (cyc - rst_rise_cyc) <= EXP_HK)) ready_viol++;
      if (done_o) done_cycles++;
      if (!p_sck && cfg_sck_o) begin
        sck_rises++;
        if (!first_sck) begin
          first_sck = 1'b1; hk_gap = cyc - rst_rise_cyc;
        end else if (cyc - last_rise < min_gap) begin
          min_gap = cyc - last_rise;
        end
        last_rise = cyc;
        shreg = {shreg[6:0], cfg_mosi_o};
        nbits++;
        if (nbits == 8) begin
          nbits = 0;
          if (exp_q.size() == 0) extra++;
          else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            tests++;
            if (e != shreg) begin
              fails++; mis++;
              $display("FAIL R6 serial byte: actual %02h expected %02h", shreg, e);
            end
          end
        end
      end
      if (cfg_cs_n_o) nbits = 0;
    end
    p_rst = cfg_rst_n_o; p_cs = cfg_cs_n_o; p_sck = cfg_sck_o;
  end

  task automatic pulse_start(input bit part, input int len);
    @(negedge clk);
    partial_i = part; len_i = 16'(len); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; partial_i = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    byte_data_i = b; byte_valid_i = 1'b1;
    do @(negedge clk); while (!byte_ready_o);
    @(posedge clk);
    #1 byte_valid_i = 1'b0;
  endtask

  // runs a load from tx_q; post_ok: target raises done after data; pre_high: target done stuck high
  task automatic do_load(input bit post_ok, input bit pre_high, input bit poke);
    int n;
    n = tx_q.size();
    tgt_done = pre_high;
    if (!pre_high) begin
      foreach (tx_q[i]) exp_q.push_back(tx_q[i]);
      if (post_ok) for (int k = 0; k < PADN; k++) exp_q.push_back(8'h00);
    end
    pulse_start(1'b0, n);
    if (poke) begin
      repeat (40) @(negedge clk);
      pulse_start(1'b0, 1);
    end
    if (!pre_high) begin
      for (int k = 0; k < n; k++) send_byte(tx_q[k]);
      if (post_ok) tgt_done = 1'b1;
    end
    do @(negedge clk); while (busy_o);
    repeat (3) @(negedge clk);
    tgt_done = 1'b0;
    tx_q.delete();
  endtask

  initial begin
    repeat (150_000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int cs0, rst0, sck0, dc0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 idle after reset
    chk(cfg_rst_n_o == 1'b1, "R1", "reset pin idle", int'(cfg_rst_n_o), 1);
    chk(cfg_cs_n_o == 1'b1, "R1", "chip select idle", int'(cfg_cs_n_o), 1);
    chk(cfg_sck_o == 1'b0, "R1", "sck idle", int'(cfg_sck_o), 0);
    chk({busy_o, done_o, err_o, byte_ready_o} == 4'b0, "R1", "flags idle",
        int'({busy_o, done_o, err_o, byte_ready_o}), 0);

    // first full load
    dc0 = done_cycles;
    tx_q = '{8'hA5, 8'h3C, 8'h01, 8'h80, 8'hFF};
    do_load(1'b1, 1'b0, 1'b0);
    chk(rst_width == EXP_RST, "R2", "reset hold cycles", rst_width, EXP_RST);
    chk(hk_gap > EXP_HK, "R4", "housekeeping gap", hk_gap, EXP_HK + 1);
    chk(min_gap == EXP_BITGAP, "R5", "sck rise spacing", min_gap, EXP_BITGAP);
    chk(exp_q.size() == 0 && extra == 0, "R9", "data and padding all seen",
        exp_q.size() + extra, 0);
    chk(done_cycles - dc0 == 1, "R11", "done pulse width", done_cycles - dc0, 1);
    chk(err_o == 1'b0, "R9", "no error after good load", int'(err_o), 0);
    chk(ready_viol == 0, "R7", "ready while shifting or waiting", ready_viol, 0);

    // second load with a start poked while busy
    cs0 = cs_falls; rst0 = rst_falls; dc0 = done_cycles;
    tx_q = '{8'h5A, 8'hC3, 8'h7E};
    do_load(1'b1, 1'b0, 1'b1);
    chk(cs_falls - cs0 == 1 && rst_falls - rst0 == 1, "R11", "start while busy ignored",
        cs_falls - cs0 + rst_falls - rst0, 2);
    chk(exp_q.size() == 0 && extra == 0, "R6", "second stream complete",
        exp_q.size() + extra, 0);
    chk(done_cycles - dc0 == 1, "R11", "second done pulse", done_cycles - dc0, 1);

    // precheck failure
    sck0 = sck_rises; dc0 = done_cycles;
    tx_q = '{8'h11, 8'h22};
    do_load(1'b0, 1'b1, 1'b0);
    chk(err_o == 1'b1, "R3", "error on done high after reset", int'(err_o), 1);
    chk(cfg_cs_n_o == 1'b1, "R3", "chip select released", int'(cfg_cs_n_o), 1);
    chk(sck_rises == sck0, "R3", "no clocks after abort", sck_rises - sck0, 0);
    repeat (20) @(negedge clk);
    chk(err_o == 1'b1, "R11", "error sticky", int'(err_o), 1);

    // next start clears error
    dc0 = done_cycles;
    tx_q = '{8'h96, 8'h69};
    pulse_start(1'b0, 2);
    chk(err_o == 1'b0, "R11", "start clears error", int'(err_o), 0);
    foreach (tx_q[i]) exp_q.push_back(tx_q[i]);
    for (int k = 0; k < PADN; k++) exp_q.push_back(8'h00);
    for (int k = 0; k < 2; k++) send_byte(tx_q[k]);
    tgt_done = 1'b1;
    do @(negedge clk); while (busy_o);
    tgt_done = 1'b0;
    tx_q.delete();
    chk(done_cycles - dc0 == 1 && exp_q.size() == 0, "R9", "recovery load done",
        done_cycles - dc0, 1);

    // postcheck failure
    dc0 = done_cycles; sck0 = sck_rises;
    tx_q = '{8'hF0, 8'h0F};
    do_load(1'b0, 1'b0, 1'b0);
    chk(err_o == 1'b1, "R8", "error on done low after data", int'(err_o), 1);
    chk(done_cycles == dc0, "R8", "no done pulse", done_cycles - dc0, 0);
    chk(sck_rises - sck0 == 16, "R8", "no padding clocks", sck_rises - sck0, 16);
    chk(exp_q.size() == 0 && extra == 0, "R6", "data before failure",
        exp_q.size() + extra, 0);

    // partial refusal
    cs0 = cs_falls; rst0 = rst_falls; sck0 = sck_rises;
    pulse_start(1'b1, 4);
    repeat (30) @(negedge clk);
    chk(err_o == 1'b1 && busy_o == 1'b0, "R10", "partial refused",
        int'({err_o, busy_o}), 2);
    chk(cs_falls == cs0 && rst_falls == rst0 && sck_rises == sck0, "R10",
        "no pin activity", cs_falls - cs0 + rst_falls - rst0 + sck_rises - sck0, 0);

    chk(idle_viol == 0, "R12", "sck high with cs released", idle_viol, 0);
    chk(ready_viol == 0, "R7", "ready quiet overall", ready_viol, 0);
    chk(mis == 0, "R6", "byte mismatches", mis, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule